// File: doc/BRIEF.md
# Boot Code Morse LED Signaller

Boot firmware writes progress or error codes into an 8-bit register. The block keeps the last value written and returns it on a read port. When a nonzero code has stayed unchanged for longer than the stability time, the block blinks the code on a single LED output. It sends one pulse per bit, from the top bit down to the bottom bit. A long pulse stands for a 1 and a short pulse for a 0.

A technician can then read the last code a stalled board reached by watching the LED. There is a fixed off time between bits. After the eighth bit there is a longer pause, and then the pattern starts again. It repeats for as long as the code does not change. A write that changes the code stops the pattern at once and restarts the stability wait. A write of the same value leaves everything as it was.

All durations are counted in millisecond ticks. A prescaler makes the tick from the clock, and its length is a parameter so that simulation can shorten every interval. The prescaler restarts on every write that changes the code, so the stability wait always begins on a tick boundary.

Top module: `boot_code_led`

## Requirements
- R1: After reset `rd_data` is 0x00. One cycle after any write, `rd_data` equals the byte written.
- R2: While the stored code is 0x00, `led` is low.
- R3: After a write that changes the code to a nonzero value, `led` stays low for at least T_STABLE_MS ms. The first pulse starts T_STABLE_MS+1 ms after that write.
- R4: A bit equal to 1 is shown as a pulse of T_LONG_MS ms. A bit equal to 0 is shown as a pulse of T_SHORT_MS ms.
- R5: Pulses are sent in the order bit 7, bit 6, and so on down to bit 0.
- R6: Between consecutive pulses of one pass, `led` is low for T_GAP_MS ms. After the bit 0 pulse, `led` is low for T_PAUSE_MS ms, and then the pattern starts again from bit 7.
- R7: A write with a value different from the stored code drives `led` low in the next cycle and restarts the stability wait of R3 from that write.
- R8: A write of the value already stored does not restart the stability wait.
- R9: `led` is low after reset, and it stays low while no sequence is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Code to store |
| rd_data | output | 8 | Last code written |
| led | output | 1 | LED drive, high means lit |

## Verification
The bench measures how long the LED stays dark after a write, with a one-cycle tolerance. A design that compares "at least" instead of "longer than" would light the LED one tick early. A design that does not restart its timer on a changing write would light it too soon after that write.

It decodes a whole pass of a mixed pattern by pulse width and by the gaps between pulses. A reversed bit order, swapped long and short widths, or a missing pause shows up as a wrong bit or a wrong gap length.

It rewrites the same value halfway through the wait. A design that treats every write as a change would then delay the first pulse. It also writes a new code in the middle of a pulse. A design without an abort would keep the LED lit.

// File: rtl/boot_code_led.sv
module boot_code_led #(
  parameter int CLK_PER_MS  = 200000,
  parameter int T_STABLE_MS = 2000,
  parameter int T_LONG_MS   = 600,
  parameter int T_SHORT_MS  = 200,
  parameter int T_GAP_MS    = 400,
  parameter int T_PAUSE_MS  = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       led
);
  localparam int PW   = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam int SW   = $clog2(T_STABLE_MS + 1);
  localparam int M1   = (T_LONG_MS > T_SHORT_MS) ? T_LONG_MS : T_SHORT_MS;
  localparam int M2   = (T_GAP_MS > T_PAUSE_MS) ? T_GAP_MS : T_PAUSE_MS;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1;

  localparam logic [PW-1:0] PRE_END  = PW'(CLK_PER_MS - 1);
  localparam logic [SW-1:0] STAB_END = SW'(T_STABLE_MS);
  localparam logic [TW-1:0] D_LONG   = TW'(T_LONG_MS - 1);
  localparam logic [TW-1:0] D_SHORT  = TW'(T_SHORT_MS - 1);
  localparam logic [TW-1:0] D_GAP    = TW'(T_GAP_MS - 1);
  localparam logic [TW-1:0] D_PAUSE  = TW'(T_PAUSE_MS - 1);

  typedef enum logic [1:0] {S_IDLE, S_ON, S_OFF, S_PAUSE} state_t;

  logic [7:0]    code;
  logic [PW-1:0] pre;
  logic [SW-1:0] stab;
  logic          done;
  state_t        state;
  logic [2:0]    idx;
  logic [TW-1:0] tmr;

  wire chg   = wr_en && (wr_data != code);
  wire tick  = (pre == PRE_END);
  wire start = tick && !done && (stab == STAB_END) && (code != 8'h00);
  wire [2:0] nidx = idx - 3'd1;

  assign rd_data = code;
  assign led     = (state == S_ON);

  always_ff @(posedge clk) begin
    if (!rst_n)     code <= 8'h00;
    else if (wr_en) code <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || chg || tick) pre <= '0;
    else                       pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || chg) begin
      stab <= '0;
      done <= 1'b0;
    end else if (tick && !done) begin
      if (stab == STAB_END) done <= 1'b1;
      else                  stab <= stab + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || chg) begin
      state <= S_IDLE;
      idx   <= 3'd7;
      tmr   <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (start) begin
            state <= S_ON;
            idx   <= 3'd7;
            tmr   <= code[7] ? D_LONG : D_SHORT;
          end
        S_ON:
          if (tick) begin
            if (tmr == '0) begin
              state <= (idx == 3'd0) ? S_PAUSE : S_OFF;
              tmr   <= (idx == 3'd0) ? D_PAUSE : D_GAP;
            end else tmr <= tmr - 1'b1;
          end
        S_OFF:
          if (tick) begin
            if (tmr == '0) begin
              state <= S_ON;
              idx   <= nidx;
              tmr   <= code[nidx] ? D_LONG : D_SHORT;
            end else tmr <= tmr - 1'b1;
          end
        default:
          if (tick) begin
            if (tmr == '0) begin
              state <= S_ON;
              idx   <= 3'd7;
              tmr   <= code[7] ? D_LONG : D_SHORT;
            end else tmr <= tmr - 1'b1;
          end
      endcase
    end
  end

  assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  assert_zero_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == 8'h00) |-> !led);

  assert_no_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
    led |-> done);

  assert_write_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !led);

  assert_same_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !chg && !tick) |=> $stable(stab) && $stable(done));
endmodule

// File: tb/boot_code_led_bench.sv
module boot_code_led_bench;
  localparam int CPM = 10, TS = 20, TL = 6, TSH = 2, TG = 4, TP = 20;
  localparam int FIRST = (TS + 1) * CPM;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic led;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  boot_code_led #(.CLK_PER_MS(CPM), .T_STABLE_MS(TS), .T_LONG_MS(TL),
                  .T_SHORT_MS(TSH), .T_GAP_MS(TG), .T_PAUSE_MS(TP))
    u_boot_code_led (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
                     .wr_data(wr_data), .rd_data(rd_data), .led(led));

  task automatic check(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // counts negedges from just after the write edge until led is high
  task automatic wait_rise(input int limit, output int n);
    n = 0;
    while (!led && n < limit) begin @(negedge clk); n++; end
    if (!led) n = -1;
  endtask

  task automatic pulse(output int hi, output int lo);
    int d;
    wait_rise(4000, d);
    hi = 0; lo = 0;
    while (led && hi < 4000) begin @(negedge clk); hi++; end
    while (!led && lo < 4000) begin @(negedge clk); lo++; end
  endtask

  task automatic t_reset;
    check("R1 reset rd_data", rd_data, 0, 0);
    check("R9 reset led", led, 0, 0);
  endtask

  task automatic t_pattern(input logic [7:0] c);
    int d, hi, lo;
    write(c);
    check("R1 readback", rd_data, c, c);
    d = 0;
    while (!led && d < 4000) begin @(negedge clk); d++; end
    check("R3 first pulse delay", d + 1, FIRST - 1, FIRST + 1);
    for (int b = 7; b >= 0; b--) begin
      hi = 0; lo = 0;
      while (led && hi < 4000) begin @(negedge clk); hi++; end
      while (!led && lo < 4000) begin @(negedge clk); lo++; end
      if (c[b]) check($sformatf("R4 R5 bit%0d long", b), hi, TL*CPM-1, TL*CPM+1);
      else      check($sformatf("R4 R5 bit%0d short", b), hi, TSH*CPM-1, TSH*CPM+1);
      if (b != 0) check("R6 gap", lo, TG*CPM-1, TG*CPM+1);
      else        check("R6 pause", lo, TP*CPM-1, TP*CPM+1);
    end
    hi = 0;
    while (led && hi < 4000) begin @(negedge clk); hi++; end
    check("R6 repeat bit7", hi, c[7] ? TL*CPM-1 : TSH*CPM-1, c[7] ? TL*CPM+1 : TSH*CPM+1);
  endtask

  task automatic t_zero;
    int d;
    write(8'h00);
    check("R2 led after zero write", led, 0, 0);
    wait_rise(3*FIRST, d);
    check("R2 zero never shown", d, -1, -1);
  endtask

  task automatic t_abort;
    int d, hi, lo;
    write(8'h3C);
    wait_rise(4000, d);
    repeat (3) @(negedge clk);
    write(8'hC3);
    check("R7 abort led low", led, 0, 0);
    wait_rise(4000, d);
    check("R7 restart delay", d + 1, FIRST - 1, FIRST + 1);
    hi = 0;
    while (led && hi < 4000) begin @(negedge clk); hi++; end
    check("R7 new code bit7 long", hi, TL*CPM-1, TL*CPM+1);
    pulse(hi, lo);
    write(8'h00);
    check("R9 idle after zero", led, 0, 0);
    wait_rise(2*FIRST, d);
    check("R9 stays dark", d, -1, -1);
  endtask

  task automatic t_same;
    int d, d2;
    write(8'h81);
    wait_rise(FIRST/2, d);
    check("R8 dark before rewrite", d, -1, -1);
    write(8'h81);
    wait_rise(4000, d2);
    check("R8 no restart", FIRST/2 + 1 + d2, FIRST - 2, FIRST + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_pattern(8'hA5);
    t_zero();
    t_pattern(8'h96);
    t_abort();
    t_same();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule